// File: doc/BRIEF.md
# Modulo 2^n-1 Residue Adder with End-Around Carry

This block adds or subtracts two residues in a number channel whose modulus is 2^n-1. Arithmetic in such a channel is one's-complement arithmetic. A carry that leaves the most significant bit has to re-enter at the least significant bit. A plain adder would need a second carry pass for that re-entry. This block instead forms two n-bit sums at the same time, one with carry-in 0 and one with carry-in 1. The carry-out of the carry-in-0 sum then selects between them through a multiplexer.

Subtraction inverts the subtrahend before the dual sum. Inverting an n-bit value gives its additive inverse modulo 2^n-1. The all-ones pattern is the second encoding of zero. The block folds it to zero, so every result is a canonical value below 2^n-1.

The block is purely combinational. It has no clock, no reset and no handshake. The result follows the operands within the same cycle and is meant to sit inside a registered datapath stage.

Top module: `eac_residue_adder`

## Requirements
- R1: With `sub`=0 and both operands below 2^n-1, `sum` equals (a+b) mod (2^n-1).
- R2: With `sub`=1 and a > b (both below 2^n-1), `sum` equals a-b.
- R3: With `sub`=0 and a+b ≥ 2^n, the end-around carry applies and `sum` equals a+b+1-2^n.
- R4: With `sub`=0 and a+b exactly 2^n-1, `sum` is 0 and not the all-ones pattern.
- R5: For any in-range operands in either mode, `sum` is never the all-ones value 2^n-1.
- R6: With `sub`=1 and a = b, `sum` is 0.
- R7: With `sub`=1 and a < b, `sum` equals a-b+2^n-1.
- R8: `sum` is a combinational function of `a`, `b` and `sub`. It settles after an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, a residue below 2^WIDTH-1 |
| b | input | WIDTH | Second operand (addend or subtrahend), below 2^WIDTH-1 |
| sub | input | 1 | 0 selects a+b, 1 selects a-b |
| sum | output | WIDTH | Canonical result modulo 2^WIDTH-1 |

## Verification
The block holds no state, so any internal fault shows up at `sum` in the same cycle as the operands that exercise it. A wrong select of the carry-in-1 sum corrupts exactly the pairs whose raw sum reaches 2^n. A missing fold of all ones shows only where a+b equals the modulus, or in subtraction where a equals b. A broken inversion affects every subtraction. The exhaustive sweep at n=5 and the random pairs at n=8 reach each of these regions, and each check is tagged with the region it lands in.

// File: rtl/eac_pkg.sv
package eac_pkg;
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } eac_mode_e;
endpackage

// File: rtl/eac_operand_prep.sv
module eac_operand_prep
  import eac_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_in,
  input  eac_mode_e        mode,
  output logic [WIDTH-1:0] b_eff
);
  // Bitwise inversion is negation modulo 2^WIDTH-1.
  always_comb begin
    b_eff = (mode == MODE_SUB) ? ~b_in : b_in;
  end
endmodule

// File: rtl/eac_dual_sum.sv
module eac_dual_sum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum_c0,
  output logic [WIDTH-1:0] sum_c1,
  output logic             cout_c0
);
  localparam int XW = WIDTH + 1;
  localparam logic [XW-1:0] ONE_X = XW'(1);

  logic [XW-1:0] wide_c0;
  logic [XW-1:0] wide_c1;

  // Both carry-in cases are computed side by side.
  always_comb begin
    wide_c0 = {1'b0, opa} + {1'b0, opb};
    wide_c1 = {1'b0, opa} + {1'b0, opb} + ONE_X;
  end

  assign sum_c0  = wide_c0[WIDTH-1:0];
  assign sum_c1  = wide_c1[WIDTH-1:0];
  assign cout_c0 = wide_c0[WIDTH];

  // R3
  always_comb begin
    carry_pair_chk: assert (!cout_c0 || wide_c1[WIDTH])
      else $error("carry-in-1 sum lost the carry of the carry-in-0 sum");
  end
endmodule

// File: rtl/eac_select.sv
module eac_select #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum_c0,
  input  logic [WIDTH-1:0] sum_c1,
  input  logic             cout_c0,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] picked;

  always_comb begin
    picked = cout_c0 ? sum_c1 : sum_c0;
    result = (picked == ALL_ONES) ? '0 : picked;
  end

  // R4
  always_comb begin
    select_chk: assert (cout_c0 || sum_c0 == ALL_ONES || result == sum_c0)
      else $error("no-carry path did not pass the carry-in-0 sum");
  end
endmodule

// File: rtl/eac_residue_adder.sv
module eac_residue_adder
  import eac_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  eac_mode_e        mode;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] s0;
  logic [WIDTH-1:0] s1;
  logic             c0;

  assign mode = sub ? MODE_SUB : MODE_ADD;

  eac_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_in (b),
    .mode (mode),
    .b_eff(b_eff)
  );

  eac_dual_sum #(.WIDTH(WIDTH)) u_dual (
    .opa    (a),
    .opb    (b_eff),
    .sum_c0 (s0),
    .sum_c1 (s1),
    .cout_c0(c0)
  );

  eac_select #(.WIDTH(WIDTH)) u_sel (
    .sum_c0 (s0),
    .sum_c1 (s1),
    .cout_c0(c0),
    .result (sum)
  );

  always_comb begin
    // R5
    canon_chk: assert (a == ALL_ONES || b == ALL_ONES || sum != ALL_ONES)
      else $error("non-canonical all-ones result");
    // R1
    add_ident_chk: assert (sub || b != '0 || a == ALL_ONES || sum == a)
      else $error("adding zero changed the operand");
    // R6
    sub_self_chk: assert (!sub || a != b || a == ALL_ONES || sum == '0)
      else $error("a-a did not give zero");
  end
endmodule

// File: tb/eac_residue_adder_test.sv
module eac_residue_adder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] a5, b5, s5;
  logic [7:0] a8, b8, s8;
  logic sub5, sub8;

  eac_residue_adder #(.WIDTH(5)) uut (.a(a5), .b(b5), .sub(sub5), .sum(s5));
  eac_residue_adder #(.WIDTH(8)) uut_w8 (.a(a8), .b(b8), .sub(sub8), .sum(s8));

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ref_val(int a, int b, bit s, int m);
    if (s) return (a + m - b) % m;
    return (a + b) % m;
  endfunction

  function automatic string region(int a, int b, bit s, int m);
    if (s) begin
      if (a == b) return "R6";
      if (a < b) return "R7";
      return "R2";
    end
    if (a + b == m) return "R4";
    if (a + b > m) return "R3";
    return "R1";
  endfunction

  task automatic run5(int a, int b, bit s);
    @(negedge clk);
    a5 = 5'(a); b5 = 5'(b); sub5 = s;
    #2;
    chk(region(a, b, s, 31), int'(s5), ref_val(a, b, s, 31));
    checks++;
    if (s5 == 5'h1f) begin
      errors++;
      $display("FAIL R5: got %0d expected below 31", s5);
    end
  endtask

  task automatic run8(int a, int b, bit s);
    @(negedge clk);
    a8 = 8'(a); b8 = 8'(b); sub8 = s;
    #2;
    chk(region(a, b, s, 255), int'(s8), ref_val(a, b, s, 255));
    checks++;
    if (s8 == 8'hff) begin
      errors++;
      $display("FAIL R5: got %0d expected below 255", s8);
    end
  endtask

  initial begin
    a5 = '0; b5 = '0; sub5 = 1'b0;
    a8 = '0; b8 = '0; sub8 = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 idle zero", int'(s5), 0);
    chk("R1 idle zero w8", int'(s8), 0);
    // R8: change operands between edges and sample before the next edge
    @(negedge clk);
    a5 = 5'd20; b5 = 5'd15; sub5 = 1'b0;
    #1;
    chk("R8 settle", int'(s5), 4);
    a5 = 5'd3; sub5 = 1'b1;
    #1;
    chk("R8 resettle", int'(s5), 19);
    // exhaustive sweep at WIDTH=5
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 31; x++)
        for (int y = 0; y < 31; y++)
          run5(x, y, s[0]);
    // corners at WIDTH=8
    run8(254, 1, 1'b0);
    run8(254, 254, 1'b0);
    run8(128, 127, 1'b0);
    run8(0, 0, 1'b1);
    run8(254, 254, 1'b1);
    run8(0, 254, 1'b1);
    run8(100, 100, 1'b1);
    // random pairs at WIDTH=8
    for (int i = 0; i < 3000; i++)
      run8(int'($urandom % 255), int'($urandom % 255), 1'($urandom));
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule